// File: doc/BRIEF.md
# Time-of-Day Alarm and Periodic Pulse Generator

This block watches a free-running 64-bit nanosecond time value that an external counter supplies, together with a strobe that marks each counter step. It holds two programmable alarm times. When the time crosses an alarm value, the block raises a one-cycle event for the interrupt logic. It also drives a level on an alarm pin, and each pin has its own selectable polarity.

Next to the alarms sit several interval pulse generators, three by default. Software sets a start-request bit and then arms alarm 0. Alarm 0 is usually set one step period before a whole-second boundary. Its match starts every generator, so the first pulse lands on the step that follows the match. After that, each generator counts its programmed interval down by the step size on each counter step. When the count runs out, the generator emits a one-step pulse and reloads.

By default a later alarm-0 match realigns the pulse trains that are already running. A control bit disables this realignment. All configuration goes through a single-cycle register write port.

Top module: `tod_pulse_gen`

## Requirements
- R1: After reset, `alarm_o`, `pulse_o`, `alarm_evt_o` and `pulse_evt_o` are all zero, and every alarm is disarmed.
- R2: Alarm k fires at a step whose new time is at or above its value while the time at the previous step was below it. `alarm_evt_o[k]` is high for the one clock cycle that follows that step, and fires only once per arming. Alarm k's low word is written at select 1+2k and its high word at select 2+2k.
- R3: Writing the high word loads {high, last low word} and re-arms the alarm. Writing only the low word neither arms the alarm nor changes the value it compares against.
- R4: The alarm pin is active from the clock after a match until the next high-word write. The pin equals active XOR polarity, where control bit 31 sets the polarity of alarm 0 and bit 30 that of alarm 1. The control word is at select 0.
- R5: With control bit 28 (start request) clear, no pulse is produced, even when alarms match. Alarm 1 never starts the pulse generators.
- R6: With bit 28 set, an alarm-0 match starts each idle generator. Its first pulse comes on the next step, and later pulses come every ceil(interval/step) steps. Interval i is written at select 5+i.
- R7: A pulse drives `pulse_o[i]` high from the clock after its step until the clock after the next step. `pulse_evt_o[i]` is high for one clock only.
- R8: With control bit 14 clear, an alarm-0 match while a generator runs restarts its phase, so it pulses on the next step. With bit 14 set, such a match leaves running generators untouched.
- R9: A generator with interval 0 produces no pulses. Clearing bit 28 stops all generators and drops their pins within one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | High in the cycle where time_i holds a newly advanced value |
| time_i | input | TIME_W | Current time in nanoseconds |
| step_i | input | STEP_W | Nanoseconds added per counter step |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | ADDR_W | Register select: 0 control, 1+2k/2+2k alarm k low/high, 5+i interval i |
| wr_data_i | input | 32 | Register write data |
| alarm_o | output | 2 | Alarm pins after polarity |
| pulse_o | output | NUM_PULSE | Interval pulse pins |
| alarm_evt_o | output | 2 | One-cycle alarm event strobes |
| pulse_evt_o | output | NUM_PULSE | One-cycle pulse event strobes |

## Verification
A corrupted alarm value or arm flag shows up at the first step after the crossing: the event strobe and pin either change at the wrong step, change twice, or never change. A wrong countdown or a wrong start state in a generator moves pulses by whole steps, and this is visible on the first pulse after the starting match. The bench replays every step against an arithmetic model that crosses the 32-bit word boundary of the time. It checks each step's outputs and then checks again one clock later, which catches strobes that are too long and pins that are dropped.

// File: rtl/tod_pulse_pkg.sv
package tod_pulse_pkg;
  localparam int WORD_W         = 32;
  localparam int SEL_CTRL       = 0;
  localparam int SEL_ALM_BASE   = 1;
  localparam int SEL_IV_BASE    = 5;
  localparam int BIT_POL0       = 31;
  localparam int BIT_POL1       = 30;
  localparam int BIT_START      = 28;
  localparam int BIT_NOREALIGN  = 14;
  localparam int NUM_ALM        = 2;
endpackage

// File: rtl/tod_ctrl_regs.sv
module tod_ctrl_regs
  import tod_pulse_pkg::*;
#(
  parameter int NUM_PULSE = 3,
  parameter int INTV_W    = 32,
  parameter int ADDR_W    = 3
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic [ADDR_W-1:0]                    wr_sel_i,
  input  logic [WORD_W-1:0]                    wr_data_i,
  output logic [NUM_ALM-1:0]                   pol_o,
  output logic                                 start_en_o,
  output logic                                 realign_dis_o,
  output logic [NUM_ALM-1:0]                   lo_we_o,
  output logic [NUM_ALM-1:0]                   hi_we_o,
  output logic [NUM_PULSE-1:0][INTV_W-1:0]     intv_o
);
  localparam logic [ADDR_W-1:0] SelCtrl = ADDR_W'(SEL_CTRL);

  logic ctrl_we;
  assign ctrl_we = wr_en_i && (wr_sel_i == SelCtrl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_o         <= '0;
      start_en_o    <= 1'b0;
      realign_dis_o <= 1'b0;
    end else if (ctrl_we) begin
      pol_o[0]      <= wr_data_i[BIT_POL0];
      pol_o[1]      <= wr_data_i[BIT_POL1];
      start_en_o    <= wr_data_i[BIT_START];
      realign_dis_o <= wr_data_i[BIT_NOREALIGN];
    end
  end

  for (genvar k = 0; k < NUM_ALM; k++) begin : g_alm_we
    localparam logic [ADDR_W-1:0] SelLo = ADDR_W'(SEL_ALM_BASE + 2*k);
    localparam logic [ADDR_W-1:0] SelHi = ADDR_W'(SEL_ALM_BASE + 2*k + 1);
    assign lo_we_o[k] = wr_en_i && (wr_sel_i == SelLo);
    assign hi_we_o[k] = wr_en_i && (wr_sel_i == SelHi);
  end

  for (genvar i = 0; i < NUM_PULSE; i++) begin : g_intv
    localparam logic [ADDR_W-1:0] SelIv = ADDR_W'(SEL_IV_BASE + i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                intv_o[i] <= '0;
      else if (wr_en_i && (wr_sel_i == SelIv))    intv_o[i] <= INTV_W'(wr_data_i);
    end
  end

  // R9: the start bit is decoded from the control select only
  a_r9_start_from_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> $stable(start_en_o));
endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
  import tod_pulse_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [TIME_W-1:0] prev_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              match_o,
  output logic              evt_o,
  output logic              active_o
);
  localparam int HI_W = TIME_W - WORD_W;

  logic [WORD_W-1:0] lo_q;
  logic [TIME_W-1:0] val_q;
  logic              armed_q;

  // crossing test: time moves in step-sized jumps, so equality may be skipped
  assign match_o = armed_q && tick_i && !hi_we_i &&
                   (prev_i < val_q) && (time_i >= val_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      val_q    <= '0;
      armed_q  <= 1'b0;
      active_o <= 1'b0;
      evt_o    <= 1'b0;
    end else begin
      evt_o <= match_o;
      if (lo_we_i) lo_q <= wdata_i;
      if (hi_we_i) begin
        val_q    <= {HI_W'(wdata_i), lo_q};
        armed_q  <= 1'b1;
        active_o <= 1'b0;
      end else if (match_o) begin
        armed_q  <= 1'b0;
        active_o <= 1'b1;
      end
    end
  end

  a_r2_event_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> !armed_q);
  a_r3_no_fire_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> !evt_o);
  a_r3_high_write_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_i |=> armed_q && !active_o);
  a_r4_active_with_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> active_o);
endmodule

// File: rtl/tod_pulse_timer.sv
module tod_pulse_timer #(
  parameter int INTV_W = 32,
  parameter int STEP_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [INTV_W-1:0] intv_i,
  input  logic              en_i,
  input  logic              realign_dis_i,
  input  logic              anchor_i,
  output logic              pin_o,
  output logic              evt_o
);
  logic [INTV_W-1:0] cnt_q;
  logic              run_q;
  logic [INTV_W-1:0] step_w;
  logic              start;

  assign step_w = INTV_W'(step_i);
  assign start  = en_i && anchor_i && (!realign_dis_i || !run_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      pin_o <= 1'b0;
      evt_o <= 1'b0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      pin_o <= 1'b0;
      evt_o <= 1'b0;
    end else begin
      evt_o <= 1'b0;
      if (start) begin
        // pre-load one step so the first pulse lands on the next tick
        run_q <= 1'b1;
        cnt_q <= step_w;
        pin_o <= 1'b0;
      end else if (tick_i && run_q) begin
        if (intv_i == '0) begin
          pin_o <= 1'b0;
        end else if (cnt_q <= step_w) begin
          pin_o <= 1'b1;
          evt_o <= 1'b1;
          cnt_q <= intv_i;
        end else begin
          pin_o <= 1'b0;
          cnt_q <= cnt_q - step_w;
        end
      end
    end
  end

  a_r7_evt_with_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> pin_o);
  a_r9_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pin_o && !evt_o && !run_q);
  a_r9_zero_interval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intv_i == '0) |=> !evt_o);
  a_r6_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> !evt_o);
  a_r7_pin_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !tick_i && !anchor_i |=> $stable(pin_o));
endmodule

// File: rtl/tod_pulse_gen.sv
module tod_pulse_gen
  import tod_pulse_pkg::*;
#(
  parameter int TIME_W    = 64,
  parameter int STEP_W    = 10,
  parameter int NUM_PULSE = 3,
  parameter int INTV_W    = 32,
  localparam int ADDR_W   = $clog2(SEL_IV_BASE + NUM_PULSE)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [TIME_W-1:0]    time_i,
  input  logic [STEP_W-1:0]    step_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_sel_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  output logic [NUM_ALM-1:0]   alarm_o,
  output logic [NUM_PULSE-1:0] pulse_o,
  output logic [NUM_ALM-1:0]   alarm_evt_o,
  output logic [NUM_PULSE-1:0] pulse_evt_o
);
  logic [NUM_ALM-1:0]               pol, lo_we, hi_we, match, active;
  logic                             start_en, realign_dis;
  logic [NUM_PULSE-1:0][INTV_W-1:0] intv;
  logic [TIME_W-1:0]                prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= '0;
    else if (tick_i) prev_q <= time_i;
  end

  tod_ctrl_regs #(
    .NUM_PULSE (NUM_PULSE),
    .INTV_W    (INTV_W),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_sel_i      (wr_sel_i),
    .wr_data_i     (wr_data_i),
    .pol_o         (pol),
    .start_en_o    (start_en),
    .realign_dis_o (realign_dis),
    .lo_we_o       (lo_we),
    .hi_we_o       (hi_we),
    .intv_o        (intv)
  );

  for (genvar k = 0; k < NUM_ALM; k++) begin : g_alm
    tod_alarm_cmp #(.TIME_W(TIME_W)) u_alm (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .time_i   (time_i),
      .prev_i   (prev_q),
      .lo_we_i  (lo_we[k]),
      .hi_we_i  (hi_we[k]),
      .wdata_i  (wr_data_i),
      .match_o  (match[k]),
      .evt_o    (alarm_evt_o[k]),
      .active_o (active[k])
    );
    assign alarm_o[k] = active[k] ^ pol[k];
  end

  // only alarm 0 anchors the pulse trains
  for (genvar i = 0; i < NUM_PULSE; i++) begin : g_pp
    tod_pulse_timer #(.INTV_W(INTV_W), .STEP_W(STEP_W)) u_pp (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .tick_i        (tick_i),
      .step_i        (step_i),
      .intv_i        (intv[i]),
      .en_i          (start_en),
      .realign_dis_i (realign_dis),
      .anchor_i      (match[0]),
      .pin_o         (pulse_o[i]),
      .evt_o         (pulse_evt_o[i])
    );
  end

  a_r5_no_pulse_unstarted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_en |=> pulse_evt_o == '0);
  a_r2_event_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> alarm_evt_o == '0);
endmodule

// File: tb/sim_tod_pulse_gen.sv
module sim_tod_pulse_gen;
  localparam int CLK_P = 10;
  localparam int NP    = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [63:0] time_i = '0;
  logic [9:0]  step_i = 10'd8;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  alarm_o, alarm_evt_o;
  logic [NP-1:0] pulse_o, pulse_evt_o;

  always #(CLK_P/2) clk = ~clk;

  tod_pulse_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .time_i(time_i),
    .step_i(step_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .alarm_o(alarm_o), .pulse_o(pulse_o),
    .alarm_evt_o(alarm_evt_o), .pulse_evt_o(pulse_evt_o)
  );

  int n_chk = 0, n_bad = 0;
  string tag = "R1";

  // reference state derived from the requirements
  logic [63:0] m_val [2];
  logic [31:0] m_lo [2];
  logic [1:0]  m_armed = '0, m_act = '0, m_pol = '0;
  logic        m_start = 1'b0, m_nore = 1'b0;
  logic [31:0] m_intv [NP];
  bit          m_run [NP];
  int          m_j [NP];
  logic [63:0] m_tm = '0;
  logic [NP-1:0] m_ppin = '0;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic wr(int sel, logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = 3'(sel); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (sel == 0) begin
      m_pol = {d[30], d[31]}; m_start = d[28]; m_nore = d[14];
      if (!d[28]) begin
        for (int i = 0; i < NP; i++) m_run[i] = 0;
        m_ppin = '0;
      end
    end else if (sel >= 5) begin
      m_intv[sel-5] = d;
    end else if (sel % 2 == 1) begin
      m_lo[(sel-1)/2] = d;
    end else begin
      m_val[(sel-2)/2] = {d, m_lo[(sel-2)/2]};
      m_armed[(sel-2)/2] = 1'b1;
      m_act[(sel-2)/2] = 1'b0;
    end
  endtask

  task automatic set_alarm(int k, logic [63:0] v);
    wr(1 + 2*k, v[31:0]);
    wr(2 + 2*k, v[63:32]);
  endtask

  task automatic do_tick();
    logic [63:0] p, nt;
    logic [1:0]  m;
    logic [NP-1:0] ev;
    int n;
    p = m_tm; nt = m_tm + 64'(step_i); m_tm = nt;
    m = '0; ev = '0;
    for (int k = 0; k < 2; k++)
      if (m_armed[k] && p < m_val[k] && nt >= m_val[k]) begin
        m[k] = 1'b1; m_armed[k] = 1'b0; m_act[k] = 1'b1;
      end
    for (int i = 0; i < NP; i++) begin
      if (m[0] && m_start && (!m_nore || !m_run[i])) begin
        m_run[i] = 1; m_j[i] = 0;
      end else if (m_run[i]) begin
        m_j[i]++;
        n = (int'(m_intv[i]) + int'(step_i) - 1) / int'(step_i);
        if (m_intv[i] != 0 && ((m_j[i] - 1) % n) == 0) ev[i] = 1'b1;
      end
    end
    m_ppin = ev;
    @(negedge clk);
    time_i = nt; tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    chk("alarm event", 64'(alarm_evt_o), 64'(m));
    chk("alarm pin", 64'(alarm_o), 64'(m_act ^ m_pol));
    chk("pulse event", 64'(pulse_evt_o), 64'(ev));
    chk("pulse pin", 64'(pulse_o), 64'(m_ppin));
    @(negedge clk);
    // R7: strobes last one clock, pins hold until the next tick
    chk("event width", 64'({alarm_evt_o, pulse_evt_o}), 64'(0));
    chk("pin hold", 64'(pulse_o), 64'(m_ppin));
  endtask

  task automatic run(int n);
    for (int t = 0; t < n; t++) do_tick();
  endtask

  bit done = 0;
  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) begin m_intv[i] = '0; m_run[i] = 0; m_j[i] = 0; end
    for (int k = 0; k < 2; k++) begin m_val[k] = '0; m_lo[k] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    tag = "R1";
    chk("reset outputs", 64'({alarm_o, pulse_o, alarm_evt_o, pulse_evt_o}), 64'(0));
    rst_ni = 1'b1;
    @(negedge clk);
    chk("after release", 64'({alarm_o, pulse_o, alarm_evt_o, pulse_evt_o}), 64'(0));

    // jump time close to the 32-bit word boundary
    m_tm = 64'h0000_0000_FFFF_FF80 - 64'd8;
    run(1);

    // R2 R4 R5: alarms cross the word boundary, start bit clear
    tag = "R2 R4 R5";
    wr(0, 32'h4000_0000);
    wr(5, 32'd24); wr(6, 32'd28); wr(7, 32'd0);
    set_alarm(0, m_tm + 64'd100);
    set_alarm(1, m_tm + 64'd140);
    run(25);

    // R3: low-word write alone does not re-arm
    tag = "R3";
    wr(1, 32'(m_tm + 64'd40));
    run(10);

    // R6 R7 R9: start request, pulses every ceil(intv/step) steps, zero interval idle
    tag = "R6 R7 R9";
    wr(0, 32'h5000_0000);
    set_alarm(0, m_tm + 64'd36);
    run(30);

    // R8: realignment on a later alarm-0 match
    tag = "R8";
    set_alarm(0, m_tm + 64'd20);
    run(12);
    wr(0, 32'h5000_4000);
    set_alarm(0, m_tm + 64'd20);
    run(12);

    // R9: clearing the start bit stops the trains
    tag = "R9";
    wr(0, 32'h4000_0000);
    run(10);

    // R6: different step size and a restart from idle
    tag = "R6";
    step_i = 10'd5;
    wr(5, 32'd24); wr(7, 32'd10);
    wr(0, 32'h1000_0000);
    set_alarm(0, m_tm + 64'd13);
    run(30);

    // R2: alarm 1 re-armed, still no effect on pulses (R5)
    tag = "R2 R5";
    set_alarm(1, m_tm + 64'd7);
    run(6);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule